// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in memory. The caller hands over the virtual address together with the current page-directory base. The walker then reads one word from the directory and one word from the second-level table over a valid/ready memory port. It reports either the translated address or a fault that names the level where the walk stopped.

The virtual address has three fields. The top ten bits index the directory. The next ten bits index the second-level table. The low twelve bits are the byte offset inside the page. Every table entry is a 32-bit word. Bits 31:12 of an entry hold a frame number and bit 0 is the present flag. Entry bits 11:1 are ignored. The address of an entry is the frame of its table shifted left by twelve, ORed with the index shifted left by two.

The controller has six states. IDLE waits for a request. RD_DIR issues the directory read and WT_DIR waits for its data. RD_TBL issues the table read and WT_TBL waits for its data. REPORT shows the result for one cycle. The transitions are:

- IDLE goes to RD_DIR when a request is accepted.
- RD_DIR goes to WT_DIR when the memory takes the read.
- WT_DIR goes to RD_TBL when the returned entry is present. It goes to REPORT when the entry is absent.
- RD_TBL goes to WT_TBL when the memory takes the read.
- WT_TBL goes to REPORT when the data returns.
- REPORT always goes back to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. It shows req_ready high, and mem_req_valid, mem_rsp_ready, done and fault are all low.
- R2: The first memory read after a request is accepted goes to {dir_base[31:12], vaddr[31:22], 2'b00}.
- R3: When the directory entry has bit 0 set, the second read goes to {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R4: When the table entry has bit 0 set, done pulses and paddr equals {tbl_entry[31:12], vaddr[11:0]}.
- R5: When the directory entry has bit 0 clear, fault pulses with fault_level 0 and paddr 0. No second read is issued.
- R6: When the table entry has bit 0 clear, fault pulses with fault_level 1 and paddr 0.
- R7: A request is taken only while idle. While a walk is in progress req_ready is low, and a request held during that time does not change the walk's result. The held request is accepted once the walker is idle again.
- R8: A read request stays asserted with a stable address until mem_req_ready accepts it.
- R9: Any response latency is tolerated. mem_rsp_ready is high only while a read is outstanding, and never together with mem_req_valid.
- R10: done and fault are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Page-directory base; bits 31:12 are its frame |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker takes read data |
| mem_rsp_data | input | 32 | Entry word returned |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: an entry was absent |
| fault_level | output | 1 | 0 = directory entry absent, 1 = table entry absent |
| paddr | output | 32 | Physical address, valid with done, otherwise 0 |

## Verification
Two events can coincide. One is the one-cycle completion pulse in REPORT. The other is a new translation request, which must not be taken in that cycle. The bench holds req_valid high with a different address and base throughout a walk. The scoreboard then expects the first result unchanged and the second walk to start only after the pulse. A second coincidence is a read response arriving in the very cycle after the read is accepted, at zero latency. The memory model mixes that case with random stalls on both channels. Every issued address and every result is compared against values computed from the bench's own copy of memory.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_DIR = 3'd1,
        ST_WT_DIR = 3'd2,
        ST_RD_TBL = 3'd3,
        ST_WT_TBL = 3'd4,
        ST_REPORT = 3'd5
    } walk_state_e;

    localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OFF_W  = 12,
    localparam int unsigned FRAME_W = WORD_W - OFF_W
) (
    input  logic [WORD_W-1:0]  entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);

    always_comb begin
        present = entry[0];
        frame   = entry[WORD_W-1:OFF_W];
    end

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned DIR_W    = 10,
    parameter int unsigned TBL_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ENT_LOG2 = 2,
    localparam int unsigned FRAME_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic               sel_tbl,
    output logic [VA_W-1:0]    entry_addr
);

    logic [VA_W-1:0] lvl_addr [pt_walker_pkg::NUM_LEVELS];

    for (genvar g = 0; g < int'(pt_walker_pkg::NUM_LEVELS); g++) begin : g_lvl
        localparam int unsigned IW = (g == 0) ? DIR_W : TBL_W;
        localparam int unsigned LO = (g == 0) ? (OFF_W + TBL_W) : OFF_W;
        logic [IW-1:0]      idx;
        logic [FRAME_W-1:0] frm;
        always_comb begin
            idx = vaddr[LO +: IW];
            frm = (g == 0) ? dir_frame : tbl_frame;
            lvl_addr[g] = ({{OFF_W{1'b0}}, frm} << OFF_W)
                        | ({{(VA_W-IW){1'b0}}, idx} << ENT_LOG2);
        end
    end

    always_comb entry_addr = sel_tbl ? lvl_addr[1] : lvl_addr[0];

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        entry_present,
    output walk_state_e state,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic        mem_rsp_ready,
    output logic        ld_req,
    output logic        ld_dir,
    output logic        ld_tbl,
    output logic        sel_tbl,
    output logic        in_report
);

    walk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)     state_d = ST_RD_DIR;
            ST_RD_DIR: if (mem_req_ready) state_d = ST_WT_DIR;
            ST_WT_DIR: if (mem_rsp_valid) state_d = entry_present ? ST_RD_TBL : ST_REPORT;
            ST_RD_TBL: if (mem_req_ready) state_d = ST_WT_TBL;
            ST_WT_TBL: if (mem_rsp_valid) state_d = ST_REPORT;
            ST_REPORT:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        ld_req        = 1'b0;
        ld_dir        = 1'b0;
        ld_tbl        = 1'b0;
        sel_tbl       = 1'b0;
        in_report     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                ld_req    = req_valid;
            end
            ST_RD_DIR: mem_req_valid = 1'b1;
            ST_WT_DIR: begin
                mem_rsp_ready = 1'b1;
                ld_dir        = mem_rsp_valid;
            end
            ST_RD_TBL: begin
                mem_req_valid = 1'b1;
                sel_tbl       = 1'b1;
            end
            ST_WT_TBL: begin
                mem_rsp_ready = 1'b1;
                ld_tbl        = mem_rsp_valid;
            end
            ST_REPORT: in_report = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned DIR_W    = 10,
    parameter int unsigned TBL_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] dir_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            mem_rsp_ready,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic            fault,
    output logic            fault_level,
    output logic [VA_W-1:0] paddr
);
    import pt_walker_pkg::*;

    localparam int unsigned FRAME_W = VA_W - OFF_W;

    walk_state_e        state;
    logic               ld_req, ld_dir, ld_tbl, sel_tbl, in_report;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;

    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] tbl_q;
    logic [VA_W-1:0]    pa_q;
    logic               flt_q;
    logic               lvl_q;

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_present (ent_present),
        .state         (state),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .ld_req        (ld_req),
        .ld_dir        (ld_dir),
        .ld_tbl        (ld_tbl),
        .sel_tbl       (sel_tbl),
        .in_report     (in_report)
    );

    pt_entry_decode #(.WORD_W(VA_W), .OFF_W(OFF_W)) u_dec (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    pt_addr_gen #(
        .VA_W(VA_W), .DIR_W(DIR_W), .TBL_W(TBL_W),
        .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)
    ) u_agen (
        .vaddr      (va_q),
        .dir_frame  (base_q),
        .tbl_frame  (tbl_q),
        .sel_tbl    (sel_tbl),
        .entry_addr (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
            tbl_q  <= '0;
            pa_q   <= '0;
            flt_q  <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            if (ld_req) begin
                va_q   <= req_vaddr;
                base_q <= dir_base[VA_W-1:OFF_W];
                flt_q  <= 1'b0;
                lvl_q  <= 1'b0;
                pa_q   <= '0;
            end
            if (ld_dir) begin
                if (ent_present) begin
                    tbl_q <= ent_frame;
                end else begin
                    flt_q <= 1'b1;
                    lvl_q <= 1'b0;
                end
            end
            if (ld_tbl) begin
                if (ent_present) begin
                    pa_q <= {ent_frame, va_q[OFF_W-1:0]};
                end else begin
                    flt_q <= 1'b1;
                    lvl_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        done        = in_report && !flt_q;
        fault       = in_report && flt_q;
        fault_level = fault ? lvl_q : 1'b0;
        paddr       = done ? pa_q : '0;
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_ready,
    input logic            done,
    input logic            fault,
    input logic            fault_level,
    input logic [VA_W-1:0] paddr
);

    // R2
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req_valid);

    // R7
    idle_only_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (mem_req_valid || mem_rsp_ready || done || fault)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    rsp_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rsp_ready && mem_req_valid));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R10
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (paddr == '0));

    // R5
    lvl_only_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_level |-> fault);

endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_ready (mem_rsp_ready),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level),
    .paddr         (paddr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] dir_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault, fault_level;
    logic [31:0] paddr;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [31:0] mem [logic [31:0]];
    logic [32:0] addr_q [$];   // {is_table_read, address}
    logic [33:0] res_q  [$];   // {fault, level, paddr}

    always #10 clk = ~clk;

    pt_walker u0 (.*);

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_walk(input logic [31:0] va, input logic [31:0] base);
        logic [31:0] a1, a2, d, p;
        a1 = {base[31:12], va[31:22], 2'b00};
        d  = rd(a1);
        addr_q.push_back({1'b0, a1});
        if (!d[0]) begin
            res_q.push_back({1'b1, 1'b0, 32'h0});
        end else begin
            a2 = {d[31:12], va[21:12], 2'b00};
            addr_q.push_back({1'b1, a2});
            p = rd(a2);
            if (!p[0]) res_q.push_back({1'b1, 1'b1, 32'h0});
            else       res_q.push_back({1'b0, 1'b0, p[31:12], va[11:0]});
        end
    endtask

    task automatic wait_drain();
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_walk(input logic [31:0] va, input logic [31:0] base);
        expect_walk(va, base);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; dir_base = base;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = $urandom; dir_base = $urandom;
        wait_drain();
    endtask

    // R7: a second request is held high during the first walk
    task automatic overlap(input logic [31:0] va1, input logic [31:0] b1,
                           input logic [31:0] va2, input logic [31:0] b2);
        expect_walk(va1, b1);
        expect_walk(va2, b2);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va1; dir_base = b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_vaddr = va2; dir_base = b2;
        check(req_ready == 1'b0, "R7 busy req_ready", 64'(req_ready), 64'h0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_drain();
    endtask

    // memory model: random stalls, random latency including zero
    initial begin : memory_model
        bit req_hs = 0, rsp_hs = 0, pend = 0;
        int dly = 0;
        logic [31:0] cap, pdata;
        logic [32:0] e;
        forever begin
            @(negedge clk);
            if (rsp_hs) begin mem_rsp_valid = 1'b0; pend = 0; end
            if (req_hs) begin
                if (addr_q.size() == 0) begin
                    check(1'b0, "R5 unexpected read", 64'(cap), 64'h0);
                end else begin
                    e = addr_q.pop_front();
                    check(cap == e[31:0], e[32] ? "R3 table addr" : "R2 dir addr",
                          64'(cap), 64'(e[31:0]));
                end
                pend = 1; dly = $urandom % 4; pdata = rd(cap);
            end
            if (mem_rsp_ready)
                check(pend, "R9 rsp_ready without read", 64'(mem_rsp_ready), 64'h0);
            if (pend && !mem_rsp_valid) begin
                if (dly == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pdata; end
                else dly--;
            end
            if (!mem_rsp_valid) mem_rsp_data = $urandom;
            mem_req_ready = !pend && (($urandom % 3) != 0);
            req_hs = mem_req_valid && mem_req_ready;
            cap    = mem_req_addr;
            rsp_hs = mem_rsp_valid && mem_rsp_ready;
        end
    end

    // monitor: scoreboard compare on each completion pulse
    initial begin : monitor
        logic [33:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && (done || fault)) begin
                check(!(done && fault), "R10 exclusive", {62'h0, done, fault}, 64'h2);
                if (res_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", 64'(paddr), 64'h0);
                end else begin
                    e = res_q.pop_front();
                    if (!e[33])
                        check(done && paddr == e[31:0], "R4 translation",
                              {31'h0, fault, paddr}, {32'h0, e[31:0]});
                    else if (!e[32])
                        check(fault && !fault_level && paddr == 0, "R5 dir fault",
                              {30'h0, fault, fault_level, paddr}, {30'h0, 2'b10, 32'h0});
                    else
                        check(fault && fault_level && paddr == 0, "R6 table fault",
                              {30'h0, fault, fault_level, paddr}, {30'h0, 2'b11, 32'h0});
                end
            end
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin : driver
        logic [31:0] va, base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'h1);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'h0);
        check(mem_rsp_ready == 1'b0, "R1 mem_rsp_ready", 64'(mem_rsp_ready), 64'h0);
        check(done == 1'b0 && fault == 1'b0, "R1 pulses", {62'h0, done, fault}, 64'h0);
        rst_n = 1'b1;

        // directed tables: base frames 0x00100 / 0x00200, tables at 0x01000+
        mem[{20'h00100, 10'h001, 2'b00}] = {20'h01000, 12'hFFF};   // flags ignored
        mem[{20'h01000, 10'h002, 2'b00}] = {20'hABCDE, 12'h001};
        mem[{20'h01000, 10'h3FF, 2'b00}] = {20'h12345, 12'h003};
        mem[{20'h00100, 10'h3FF, 2'b00}] = {20'h01001, 12'h001};
        mem[{20'h01001, 10'h3FF, 2'b00}] = {20'hFFFFF, 12'h001};
        mem[{20'h00100, 10'h000, 2'b00}] = {20'h01002, 12'h001};
        mem[{20'h01002, 10'h000, 2'b00}] = {20'h55555, 12'hFFE}; // absent
        mem[{20'h00200, 10'h005, 2'b00}] = {20'h01003, 12'hFFE}; // absent

        do_walk({10'h001, 10'h002, 12'h345}, 32'h0010_0ABC); // R4
        do_walk({10'h001, 10'h3FF, 12'h000}, 32'h0010_0000); // R4
        do_walk(32'hFFFF_FFFF, 32'h0010_0FFF);               // R4 all ones
        do_walk(32'h0000_0000, 32'h0010_0000);               // R6
        do_walk({10'h005, 10'h001, 12'h010}, 32'h0020_0000); // R5 flags set but absent
        do_walk({10'h2AA, 10'h001, 12'h010}, 32'h0020_0000); // R5 empty entry

        overlap({10'h001, 10'h002, 12'h777}, 32'h0010_0000,
                32'hFFFF_F123, 32'h0010_0000);                // R7
        overlap({10'h005, 10'h000, 12'h000}, 32'h0020_0000,
                {10'h001, 10'h3FF, 12'hABC}, 32'h0010_0000);  // R7 after fault

        // random tables and requests (R2, R3, R4, R5, R6, R8, R9)
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a1, a2;
            va   = $urandom;
            base = (i % 2 == 0) ? 32'h0010_0000 : 32'h0020_0000;
            a1   = {base[31:12], va[31:22], 2'b00};
            if (!mem.exists(a1))
                mem[a1] = {20'h01010 + 20'(i % 8), 11'($urandom), ($urandom % 5) != 0};
            if (mem[a1][0]) begin
                a2 = {mem[a1][31:12], va[21:12], 2'b00};
                if (!mem.exists(a2))
                    mem[a2] = {20'($urandom), 11'($urandom), ($urandom % 4) != 0};
            end
            do_walk(va, base);
        end

        repeat (5) @(negedge clk);
        check(addr_q.size() == 0 && res_q.size() == 0, "R5 leftover expectations",
              64'(addr_q.size() + res_q.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule